// File: doc/BRIEF.md
# Four-Stage Escalating Watchdog

This block watches for a missing service signal and escalates through four timed stages when software stops servicing it. Each stage counts clock cycles up to its own programmed limit. When that limit is reached, the stage performs its chosen action and hands over to the next stage. The possible actions are: do nothing, raise an interrupt, pulse the CPU reset, pulse the system reset, or pulse the system reset together with the always-on domain reset. After the fourth stage has fired, the block stays idle until it is fed or disabled.

Software reaches the block over a simple word-addressed bus with write and read strobes. A write to the feed register sends the sequencer back to stage 0 with a cleared count. All configuration is guarded by a write lock, which only a fixed 32-bit key removes. The usual way to change settings is: unlock, disable, program, enable, then lock again.

Each reset output has its own 3-bit pulse-width code, which selects 1, 2, 3, 4, 5, 8, 16 or 32 ticks of a 10 MHz timing tick. One tick is `TICK_DIV` clock cycles.

Top module: `escal_wdog`

## Requirements
- R1: After reset, the block is disabled and unlocked. All stage limits are 0, all stage actions are 0 (none), both width codes are 0, and every output is low.
- R2: A stage with limit T fires on the (T+1)th clock edge after the edge on which it was entered. Stage 0 is entered by the edge that writes enable = 1. Stages fire in order 0, 1, 2, 3, and no stage fires after stage 3 until a feed or a disable. Register 7 reads back the stage in bits [1:0] and the idle-after-last flag in bit 2.
- R3: Action codes are 0 none, 1 interrupt, 2 CPU reset pulse, 3 system reset pulse, and 4 system reset pulse with `aon_rst_o` high for the same width.
- R4: Any write to register 2 (feed) sets the stage to 0 and the count to 0. A stage cannot fire on the same edge as a feed.
- R5: Writing 0 to bit 0 of register 0 (enable, readable) stops counting and returns the sequencer to stage 0.
- R6: Pulse width in clock cycles equals ticks × `TICK_DIV`. The tick count is 1, 2, 3, 4, 5, 8, 16 or 32 for codes 0 to 7. Register 4 holds the system code in bits [2:0] and the CPU code in bits [6:4].
- R7: A reset pulse that has started runs its full width, even if the block is disabled or fed while it is high. A new trigger during a pulse is ignored.
- R8: Register 1 reads back the lock in bit 0. Writing `UNLOCK_KEY` to register 1 clears the lock, and writing any other value sets it. While the lock is set, writes to registers 0, 4, 5 and 6 are ignored.
- R9: Register 5 sets an action, with the stage in bits [18:16] and the code in bits [2:0]. Register 6 sets a limit, with the stage in bits [30:28] and the limit in the low bits. A stage index above 3, or an action code above 4, changes nothing. Registers 8+s and 12+s read back the limit and the action of stage s.
- R10: `irq_o` stays high until a write to register 3 with bit 0 = 1 clears it. Register 3 reads back the interrupt in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; `bus_rdata` is zero when it is low |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq_o | output | 1 | Sticky watchdog interrupt |
| cpu_rst_o | output | 1 | CPU reset pulse |
| sys_rst_o | output | 1 | System reset pulse |
| aon_rst_o | output | 1 | Always-on domain reset pulse |

## Verification
The hardest situation to reach is the always-on reset at the end of the chain. The sequencer must pass through three earlier stages, and the system pulse from stage 2 must have ended before stage 3 fires, or the new trigger is swallowed. The bench programs a long stage 3 limit so the two system pulses are separated. It records every output on every cycle from the enable edge onward and compares each cycle against a timeline worked out from the limits. A second hard case is a pulse that outlives a disable and a feed. Here a counting process runs alongside the bus writes and measures the full pulse width.

// File: rtl/escal_wdog_pkg.sv
// Shared constants for the four-stage watchdog: register addresses,
// action codes and the pulse-width code table.
// Assumes a 4-bit word address on the bus.
package escal_wdog_pkg;

    localparam int NSTG  = 4;   // number of cascaded stages
    localparam int NRST  = 2;   // reset outputs: 0 system, 1 CPU
    localparam int ACT_W = 3;

    localparam logic [3:0] ADR_CTRL  = 4'd0;
    localparam logic [3:0] ADR_LOCK  = 4'd1;
    localparam logic [3:0] ADR_FEED  = 4'd2;
    localparam logic [3:0] ADR_IRQC  = 4'd3;
    localparam logic [3:0] ADR_PULSE = 4'd4;
    localparam logic [3:0] ADR_ACTW  = 4'd5;
    localparam logic [3:0] ADR_TIMEW = 4'd6;
    localparam logic [3:0] ADR_STAT  = 4'd7;

    typedef enum logic [ACT_W-1:0] {
        ACT_NONE = 3'd0,
        ACT_IRQ  = 3'd1,
        ACT_CPU  = 3'd2,
        ACT_SYS  = 3'd3,
        ACT_AON  = 3'd4
    } act_t;

    // Tick count for a 3-bit width code: 1..5, then 8, 16, 32.
    function automatic int pulse_ticks(input logic [2:0] code);
        if (code < 3'd5) return int'(code) + 1;
        return 1 << (int'(code) - 2);
    endfunction

endpackage

// File: rtl/escal_wdog_regs.sv
// Register file and write lock for the watchdog.
// Decodes bus writes into configuration, feed and interrupt-clear strobes.
// Read data is combinational. Assumes TIME_W <= 28.
module escal_wdog_regs
    import escal_wdog_pkg::*;
#(
    parameter int          TIME_W     = 24,
    parameter logic [31:0] UNLOCK_KEY = 32'hC0DE_5A17
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr,
    input  logic                              rd,
    input  logic [3:0]                        addr,
    input  logic [31:0]                       wdata,
    input  logic [1:0]                        stage,
    input  logic                              done,
    input  logic                              irq,
    output logic [31:0]                       rdata,
    output logic                              en,
    output logic                              locked,
    output logic                              feed,
    output logic                              irq_clr,
    output logic [NSTG-1:0][TIME_W-1:0]       limits,
    output logic [NSTG-1:0][ACT_W-1:0]        acts,
    output logic [NRST-1:0][2:0]              codes
);

    logic cfg_wr;
    assign cfg_wr = wr && !locked;

    // Strobes that are never blocked by the lock.
    assign feed    = wr && (addr == ADR_FEED);
    assign irq_clr = wr && (addr == ADR_IRQC) && wdata[0];

    // Lock state: the key clears it, any other value sets it.
    always_ff @(posedge clk) begin
        if (!rst_n)                          locked <= 1'b0;
        else if (wr && addr == ADR_LOCK)     locked <= (wdata != UNLOCK_KEY);
    end

    // Configuration registers, written only while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en     <= 1'b0;
            limits <= '0;
            acts   <= '0;
            codes  <= '0;
        end else if (cfg_wr) begin
            case (addr)
                ADR_CTRL:  en <= wdata[0];
                ADR_PULSE: begin
                    codes[0] <= wdata[2:0];
                    codes[1] <= wdata[6:4];
                end
                ADR_ACTW:
                    if (wdata[18:16] < 3'(NSTG) && wdata[2:0] <= ACT_AON)
                        acts[wdata[17:16]] <= wdata[2:0];
                ADR_TIMEW:
                    if (wdata[30:28] < 3'(NSTG))
                        limits[wdata[29:28]] <= wdata[TIME_W-1:0];
                default: ;
            endcase
        end
    end

    // Read mux; addresses 8..15 map to per-stage limits and actions.
    always_comb begin
        rdata = '0;
        if (rd) begin
            if (addr[3]) begin
                if (addr[2]) rdata = 32'(acts[addr[1:0]]);
                else         rdata = 32'(limits[addr[1:0]]);
            end else begin
                case (addr)
                    ADR_CTRL:  rdata = {31'd0, en};
                    ADR_LOCK:  rdata = {31'd0, locked};
                    ADR_IRQC:  rdata = {31'd0, irq};
                    ADR_PULSE: rdata = {25'd0, codes[1], 1'b0, codes[0]};
                    ADR_STAT:  rdata = {29'd0, done, stage};
                    default:   rdata = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/escal_wdog_seq.sv
// Stage sequencer: one shared counter compared against the limit of the
// current stage. Raises fire for one cycle when a stage expires, then
// advances. After the last stage it idles until feed or disable.
module escal_wdog_seq
    import escal_wdog_pkg::*;
#(
    parameter int TIME_W = 24
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         en,
    input  logic                         feed,
    input  logic [NSTG-1:0][TIME_W-1:0]  limits,
    input  logic [NSTG-1:0][ACT_W-1:0]   acts,
    output logic                         fire,
    output logic [ACT_W-1:0]             fire_act,
    output logic [1:0]                   stage,
    output logic                         done
);

    logic [TIME_W-1:0] cnt_q;

    // Expiry detect; a feed in the same cycle takes priority.
    always_comb begin
        fire     = en && !done && !feed && (cnt_q == limits[stage]);
        fire_act = acts[stage];
    end

    // Counter and stage advance.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || feed) begin
            cnt_q <= '0;
            stage <= '0;
            done  <= 1'b0;
        end else if (fire) begin
            cnt_q <= '0;
            if (stage == 2'(NSTG - 1)) done  <= 1'b1;
            else                       stage <= stage + 1'b1;
        end else if (!done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/escal_wdog_pulse.sv
// Reset pulse stretcher. A start while idle raises active for
// pulse_ticks(code) * TICK_DIV cycles; starts while active are ignored.
module escal_wdog_pulse
    import escal_wdog_pkg::*;
#(
    parameter int TICK_DIV = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [2:0] code,
    output logic       active
);

    localparam int MAXW  = 32 * TICK_DIV;
    localparam int CNT_W = $clog2(MAXW + 1);

    logic [CNT_W-1:0] left_q;
    logic [CNT_W-1:0] width;

    // Selected width in clock cycles.
    assign width = CNT_W'(pulse_ticks(code) * TICK_DIV);

    // Load on an accepted start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            left_q <= '0;
        end else if (start && !active) begin
            active <= 1'b1;
            left_q <= width - 1'b1;
        end else if (active) begin
            if (left_q == '0) active <= 1'b0;
            else              left_q <= left_q - 1'b1;
        end
    end

endmodule

// File: rtl/escal_wdog.sv
// Four-stage escalating watchdog top. Joins the register file, the
// sequencer and one pulse stretcher per reset output. Actions are
// decoded here, and the interrupt is held until cleared.
module escal_wdog
    import escal_wdog_pkg::*;
#(
    parameter int          TIME_W     = 24,
    parameter int          TICK_DIV   = 10,
    parameter logic [31:0] UNLOCK_KEY = 32'hC0DE_5A17
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq_o,
    output logic        cpu_rst_o,
    output logic        sys_rst_o,
    output logic        aon_rst_o
);

    logic                        en_q, locked_q, feed, irq_clr;
    logic [NSTG-1:0][TIME_W-1:0] limits;
    logic [NSTG-1:0][ACT_W-1:0]  acts;
    logic [NRST-1:0][2:0]        codes;
    logic                        fire, done_q;
    logic [ACT_W-1:0]            fire_act;
    logic [1:0]                  stage;
    logic [NRST-1:0]             rst_start, rst_act;
    logic                        irq_q, aon_q;

    escal_wdog_regs #(.TIME_W(TIME_W), .UNLOCK_KEY(UNLOCK_KEY)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
        .wdata(bus_wdata), .stage(stage), .done(done_q), .irq(irq_q),
        .rdata(bus_rdata), .en(en_q), .locked(locked_q), .feed(feed),
        .irq_clr(irq_clr), .limits(limits), .acts(acts), .codes(codes)
    );

    escal_wdog_seq #(.TIME_W(TIME_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .en(en_q), .feed(feed), .limits(limits),
        .acts(acts), .fire(fire), .fire_act(fire_act), .stage(stage),
        .done(done_q)
    );

    // Action decode into per-output start strobes (0 system, 1 CPU).
    always_comb begin
        rst_start[0] = fire && (fire_act == ACT_SYS || fire_act == ACT_AON);
        rst_start[1] = fire && (fire_act == ACT_CPU);
    end

    for (genvar g = 0; g < NRST; g++) begin : g_rst
        escal_wdog_pulse #(.TICK_DIV(TICK_DIV)) u_pulse (
            .clk(clk), .rst_n(rst_n), .start(rst_start[g]),
            .code(codes[g]), .active(rst_act[g])
        );
    end

    // Sticky interrupt; a new expiry wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= (irq_q && !irq_clr) || (fire && fire_act == ACT_IRQ);
    end

    // Marks a system pulse that was started by the always-on action.
    always_ff @(posedge clk) begin
        if (!rst_n)                         aon_q <= 1'b0;
        else if (rst_start[0] && !rst_act[0]) aon_q <= (fire_act == ACT_AON);
        else if (!rst_act[0])               aon_q <= 1'b0;
    end

    assign irq_o     = irq_q;
    assign sys_rst_o = rst_act[0];
    assign cpu_rst_o = rst_act[1];
    assign aon_rst_o = rst_act[0] && aon_q;

endmodule

// File: rtl/escal_wdog_chk.sv
// Property checker for the watchdog, attached by bind.
// Watches bus ports, outputs and sequencer state.
module escal_wdog_chk
    import escal_wdog_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic [3:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic        en_q,
    input logic        locked_q,
    input logic [1:0]  stage,
    input logic        done_q,
    input logic        fire,
    input logic        irq_o,
    input logic        cpu_rst_o,
    input logic        sys_rst_o,
    input logic        aon_rst_o
);

    assert_idle_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !fire);

    assert_aon_with_sys_R3: assert property (@(posedge clk) disable iff (!rst_n)
        aon_rst_o |-> sys_rst_o);

    assert_feed_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADR_FEED) |=> (stage == 2'd0 && !done_q));

    assert_disable_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> (stage == 2'd0 && !done_q));

    assert_sys_min_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_o) |=> sys_rst_o);

    assert_cpu_min_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_rst_o) |=> cpu_rst_o);

    assert_locked_ctrl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_q && bus_wr && bus_addr == ADR_CTRL) |=> $stable(en_q));

    assert_irq_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !(bus_wr && bus_addr == ADR_IRQC && bus_wdata[0])) |=> irq_o);

endmodule

bind escal_wdog escal_wdog_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .en_q(en_q), .locked_q(locked_q), .stage(stage),
    .done_q(done_q), .fire(fire), .irq_o(irq_o), .cpu_rst_o(cpu_rst_o),
    .sys_rst_o(sys_rst_o), .aon_rst_o(aon_rst_o)
);

// File: tb/sim_escal_wdog.sv
// Directed bench for the four-stage watchdog; one task per scenario.
module sim_escal_wdog;

    localparam logic [31:0] KEY = 32'hC0DE_5A17;
    localparam int          TDIV = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, cpu_rst_o, sys_rst_o, aon_rst_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    escal_wdog #(.TIME_W(24), .TICK_DIV(TDIV), .UNLOCK_KEY(KEY)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .cpu_rst_o(cpu_rst_o), .sys_rst_o(sys_rst_o),
        .aon_rst_o(aon_rst_o)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One write; returns on the falling edge after the capturing edge.
    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic set_stage(input int s, input int lim, input int act);
        bus_write(4'd6, (32'(s) << 28) | 32'(lim));
        bus_write(4'd5, (32'(s) << 16) | 32'(act));
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check(!irq_o && !cpu_rst_o && !sys_rst_o && !aon_rst_o, "R1 outputs",
              {irq_o, cpu_rst_o, sys_rst_o, aon_rst_o}, 0);
        bus_read(4'd0, d); check(d == 0, "R1 enable", d, 0);
        bus_read(4'd1, d); check(d == 0, "R1 lock", d, 0);
        bus_read(4'd9, d); check(d == 0, "R1 limit1", d, 0);
        bus_read(4'd13, d); check(d == 0, "R1 action1", d, 0);
    endtask

    // R2/R3: full chain timeline, recorded per cycle from the enable edge.
    task automatic t_chain();
        int bad_i = 0, bad_c = 0, bad_s = 0, bad_a = 0;
        logic [31:0] d;
        set_stage(0, 4, 1); set_stage(1, 2, 2); set_stage(2, 3, 3); set_stage(3, 20, 4);
        bus_write(4'd0, 1);
        for (int k = 1; k <= 60; k++) begin
            @(negedge clk);
            if (irq_o != (k >= 5)) bad_i++;
            if (cpu_rst_o != (k >= 8 && k <= 17)) bad_c++;
            if (sys_rst_o != ((k >= 12 && k <= 21) || (k >= 33 && k <= 42))) bad_s++;
            if (aon_rst_o != (k >= 33 && k <= 42)) bad_a++;
        end
        check(bad_i == 0, "R2 interrupt timeline", bad_i, 0);
        check(bad_c == 0, "R3 cpu pulse timeline", bad_c, 0);
        check(bad_s == 0, "R3 sys pulse timeline", bad_s, 0);
        check(bad_a == 0, "R3 aon pulse timeline", bad_a, 0);
        bus_read(4'd7, d); check(d == 32'h7, "R2 idle after stage 3", d, 7);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        bus_write(4'd0, 0);
        repeat (5) @(negedge clk);
        check(irq_o, "R10 held after disable", irq_o, 1);
        bus_write(4'd3, 0);
        check(irq_o, "R10 clear with bit0=0", irq_o, 1);
        bus_read(4'd3, d); check(d == 1, "R10 readback", d, 1);
        bus_write(4'd3, 1);
        check(!irq_o, "R10 cleared", irq_o, 0);
    endtask

    task automatic t_feed();
        logic [31:0] d;
        set_stage(0, 6, 1); set_stage(1, 100, 0); set_stage(2, 100, 0); set_stage(3, 100, 0);
        bus_write(4'd0, 1);
        repeat (3) @(negedge clk);
        bus_write(4'd2, 0);
        repeat (6) @(negedge clk);
        check(!irq_o, "R4 no fire before restart limit", irq_o, 0);
        @(negedge clk);
        check(irq_o, "R4 fire at restart limit", irq_o, 1);
        bus_read(4'd7, d); check(d == 1, "R4 in stage 1", d, 1);
        bus_write(4'd2, 0);
        bus_read(4'd7, d); check(d == 0, "R4 feed back to stage 0", d, 0);
        bus_write(4'd0, 0);
        bus_write(4'd3, 1);
    endtask

    task automatic t_disable();
        logic [31:0] d;
        set_stage(0, 3, 0); set_stage(1, 3, 0); set_stage(2, 100, 1);
        bus_write(4'd0, 1);
        repeat (10) @(negedge clk);
        bus_read(4'd7, d); check(d == 2, "R5 reached stage 2", d, 2);
        bus_write(4'd0, 0);
        bus_read(4'd7, d); check(d == 0, "R5 disable to stage 0", d, 0);
        repeat (120) @(negedge clk);
        check(!irq_o, "R5 no counting while disabled", irq_o, 0);
        set_stage(2, 100, 0);
    endtask

    task automatic t_widths();
        int n;
        set_stage(0, 0, 3);
        for (int c = 0; c < 8; c++) begin
            bus_write(4'd4, 32'(c));
            bus_write(4'd0, 1);
            n = 0;
            repeat (400) begin @(negedge clk); if (sys_rst_o) n++; end
            bus_write(4'd0, 0);
            check(n == (c < 5 ? c + 1 : 1 << (c - 2)) * TDIV, "R6 sys width", n,
                  (c < 5 ? c + 1 : 1 << (c - 2)) * TDIV);
        end
        set_stage(0, 0, 2);
        bus_write(4'd4, 32'h57);
        bus_write(4'd0, 1);
        n = 0;
        begin
            int s = 0;
            repeat (200) begin @(negedge clk); if (cpu_rst_o) n++; if (sys_rst_o) s++; end
            check(s == 0, "R6 sys idle on cpu action", s, 0);
        end
        bus_write(4'd0, 0);
        check(n == 8 * TDIV, "R6 cpu width code 5", n, 8 * TDIV);
    endtask

    task automatic t_full_width();
        int n = 0;
        set_stage(0, 0, 3);
        bus_write(4'd4, 32'h3);
        bus_write(4'd0, 1);
        fork
            repeat (150) begin @(negedge clk); if (sys_rst_o) n++; end
            begin bus_write(4'd0, 0); bus_write(4'd2, 0); end
        join
        check(n == 4 * TDIV, "R7 pulse survives disable and feed", n, 4 * TDIV);
    endtask

    task automatic t_lock();
        logic [31:0] d;
        bus_write(4'd1, 0);
        bus_read(4'd1, d); check(d == 1, "R8 lock set", d, 1);
        bus_write(4'd0, 1);
        bus_read(4'd0, d); check(d == 0, "R8 enable blocked", d, 0);
        bus_write(4'd6, 32'd77);
        bus_read(4'd8, d); check(d == 0, "R8 limit blocked", d, 0);
        bus_write(4'd1, 32'h1234_5678);
        bus_read(4'd1, d); check(d == 1, "R8 wrong key", d, 1);
        bus_write(4'd1, KEY);
        bus_read(4'd1, d); check(d == 0, "R8 key unlocks", d, 0);
        bus_write(4'd0, 1);
        bus_read(4'd0, d); check(d == 1, "R8 enable after unlock", d, 1);
        bus_write(4'd0, 0);
    endtask

    task automatic t_invalid();
        logic [31:0] d;
        set_stage(1, 9, 1);
        bus_write(4'd5, (32'd4 << 16) | 32'd2);
        bus_write(4'd5, (32'd1 << 16) | 32'd5);
        bus_read(4'd13, d); check(d == 1, "R9 bad code or index keeps action", d, 1);
        bus_read(4'd12, d); check(d == 3, "R9 stage0 action untouched", d, 3);
        bus_write(4'd6, (32'd5 << 28) | 32'd44);
        bus_read(4'd9, d); check(d == 9, "R9 bad index keeps limit", d, 9);
        bus_read(4'd8, d); check(d == 0, "R9 stage0 limit untouched", d, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_chain();
        t_irq();
        t_feed();
        t_disable();
        t_widths();
        t_full_width();
        t_lock();
        t_invalid();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule